// File: doc/BRIEF.md
# Divided-Clock Phase Difference Meter

This block compares the phase of an unknown periodic signal against a reference signal. Both signals arrive already synchronised to the system clock. Each one passes through its own programmable edge divider, which brings it down to a shared comparison rate. A one-bit set/clear phase detector then produces a pulse-width-modulated line. The reference event drives that line high and the unknown event drives it low, so the fraction of time the line is high follows the phase offset.

The same line is also measured in the digital domain. A saturating counter adds up the system-clock cycles during which the line is high. At every divided reference event the total is captured as a phase word, and a one-cycle valid strobe goes out with it. The word is the delay, in system-clock cycles, from a reference event to the unknown event that follows it. When the two divided rates differ slightly, the word ramps and folds back to zero once per full cycle of slip, which gives a sawtooth.

Timing: a rising input is sampled at clock edge k, and its divided event is registered at edge k. The PWM line, the phase word and the valid strobe change at edge k+1.

Top module: `divphase_meter`

## Requirements
- R1: While `rst_n` is low, `pwm_out`, `phase_word` and `phase_valid` read 0, and both dividers restart their edge count from zero.
- R2: A divider with ratio R produces one event on every R-th rising edge of its input, the first on the R-th edge after reset. A ratio of 0 behaves as a ratio of 1.
- R3: `pwm_out` goes high on the cycle after a divided reference event and goes low on the cycle after a divided unknown event. It therefore stays high for exactly the event-to-event delay in cycles.
- R4: If divided reference and unknown events fall in the same cycle, `pwm_out` stays low. The period that starts at that event then reports a phase word of 0.
- R5: At each divided reference event the block latches into `phase_word` the number of cycles `pwm_out` was high since the previous reference event. `phase_valid` is high for exactly one cycle, together with the new word.
- R6: The first divided reference event after reset opens a period and raises no valid strobe. With K reference events, K-1 strobes are produced.
- R7: When the unknown rate is slightly higher than the reference rate, successive phase words count down. They wrap from 0 back up to near the full period, which is the sawtooth fold.
- R8: The high-time count saturates at 2^CNT_W-1. With no unknown events the word reads all ones, while `pwm_out` stays high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal, synchronous to clk |
| unk_in | input | 1 | Unknown signal, synchronous to clk |
| ref_ratio | input | DIV_W | Reference divide ratio (0 acts as 1) |
| unk_ratio | input | DIV_W | Unknown divide ratio (0 acts as 1) |
| pwm_out | output | 1 | Phase detector PWM line |
| phase_word | output | CNT_W | High-time count of the last full period |
| phase_valid | output | 1 | One-cycle strobe for a new phase word |

## Verification
The bench builds the block with DIV_W=8 and CNT_W=5. With these values the comparison periods are only 20 to 64 cycles long, so several full periods fit into each short run. A 40-cycle period with no unknown input drives the 5-bit counter into saturation, while the PWM line visibly stays high longer than the word can express. Mixed ratio pairs, a zero ratio, an exact coincidence and a 19-against-20-cycle slip exercise the divider terminal count, the clear-over-set priority and the fold from 0 back to 18.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_UNK = 1;

  typedef struct packed {
    logic ref_ev;
    logic unk_ev;
  } ev_pair_t;
endpackage

// File: rtl/pm_edge_div.sv
module pm_edge_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             ev_o
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic             prev_q, prev_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ev_q, ev_d;
  logic             rise;
  logic [DIV_W-1:0] term;

  // next state: count rising edges, pulse on terminal count and reload
  always_comb begin
    rise   = sig_i & ~prev_q;
    term   = (ratio_i == '0) ? '0 : (ratio_i - ONE);
    prev_d = sig_i;
    cnt_d  = cnt_q;
    ev_d   = 1'b0;
    if (rise) begin
      if (cnt_q >= term) begin
        cnt_d = '0;
        ev_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      ev_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
      ev_q   <= ev_d;
    end
  end

  assign ev_o = ev_q;

  // R2: an event needs a fresh rising edge, so it never lasts two cycles
  p_ev_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q |=> !ev_q);
endmodule

// File: rtl/pm_phase_det.sv
module pm_phase_det
  import pm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ev_pair_t ev_i,
  output logic     pwm_o
);
  logic pwm_q, pwm_d;

  // clear wins over set, so a coincident pair leaves the line low
  always_comb begin
    pwm_d = pwm_q;
    if (ev_i.unk_ev)      pwm_d = 1'b0;
    else if (ev_i.ref_ev) pwm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.ref_ev && !ev_i.unk_ev) |=> pwm_o);

  p_coinc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.unk_ev |=> !pwm_o);
endmodule

// File: rtl/pm_duty_cnt.sv
module pm_duty_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ev_i,
  input  logic             pwm_i,
  output logic [CNT_W-1:0] word_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] acc_q, acc_d, word_q, word_d, total;
  logic             started_q, started_d, valid_q, valid_d;

  always_comb begin
    total     = acc_q;
    if (pwm_i && acc_q != MAX) total = acc_q + ONE;
    acc_d     = total;
    word_d    = word_q;
    valid_d   = 1'b0;
    started_d = started_q;
    if (ref_ev_i) begin
      acc_d     = '0;
      word_d    = total;
      valid_d   = started_q;
      started_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      word_q    <= '0;
      started_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      word_q    <= word_d;
      started_q <= started_d;
      valid_q   <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_first_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ev_i && !started_q) |=> !valid_q);

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == MAX && pwm_i && !ref_ev_i) |=> acc_q == MAX);
endmodule

// File: rtl/divphase_meter.sv
module divphase_meter
  import pm_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             unk_in,
  input  logic [DIV_W-1:0] ref_ratio,
  input  logic [DIV_W-1:0] unk_ratio,
  output logic             pwm_out,
  output logic [CNT_W-1:0] phase_word,
  output logic             phase_valid
);
  logic [NUM_CH-1:0] sig_vec;
  logic [DIV_W-1:0]  ratio_vec [NUM_CH];
  logic [NUM_CH-1:0] ev_vec;
  ev_pair_t          ev;

  assign sig_vec[CH_REF]   = ref_in;
  assign sig_vec[CH_UNK]   = unk_in;
  assign ratio_vec[CH_REF] = ref_ratio;
  assign ratio_vec[CH_UNK] = unk_ratio;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_div
    pm_edge_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .sig_i   (sig_vec[g]),
      .ratio_i (ratio_vec[g]),
      .ev_o    (ev_vec[g])
    );
  end

  assign ev.ref_ev = ev_vec[CH_REF];
  assign ev.unk_ev = ev_vec[CH_UNK];

  pm_phase_det u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_i  (ev),
    .pwm_o (pwm_out)
  );

  pm_duty_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_ev_i (ev.ref_ev),
    .pwm_i    (pwm_out),
    .word_o   (phase_word),
    .valid_o  (phase_valid)
  );

  // R1: reset holds every output quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!pwm_out && !phase_valid && phase_word == '0));
endmodule

// File: tb/divphase_meter_tb_top.sv
module divphase_meter_tb_top;
  localparam int DIV_W = 8;
  localparam int CNT_W = 5;
  localparam int NV = 6;
  // columns: ref spacing, ref ratio, unk spacing, unk ratio, unk offset, expected phase
  localparam int VEC [NV][6] = '{
    '{4,  5,  4, 5, 3, 3},
    '{2, 10,  5, 4, 0, 17},
    '{4,  5,  4, 5, 0, 0},
    '{5,  4, 10, 2, 1, 16},
    '{20, 1, 20, 0, 7, 7},
    '{8,  8,  8, 8, 5, 5}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ref_in, unk_in;
  logic [DIV_W-1:0] ref_ratio, unk_ratio;
  logic pwm_out, phase_valid;
  logic [CNT_W-1:0] phase_word;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mon_on = 0;
  int n_valid, pwm_cnt;
  int exp_w [8];
  int exp_p [8];
  string tag_w, tag_p;

  always #10 clk = ~clk;

  divphase_meter #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .unk_in(unk_in),
    .ref_ratio(ref_ratio), .unk_ratio(unk_ratio),
    .pwm_out(pwm_out), .phase_word(phase_word), .phase_valid(phase_valid)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // words compared on each strobe; PWM high time per period after the first strobe
  always @(negedge clk) begin
    if (mon_on) begin
      if (phase_valid) begin
        if (n_valid < 8) begin
          chk(tag_w, int'(phase_word), exp_w[n_valid]);
          if (n_valid > 0) chk(tag_p, pwm_cnt, exp_p[n_valid]);
        end
        pwm_cnt = 0;
        n_valid++;
      end
      if (pwm_out) pwm_cnt++;
    end
  end

  task automatic run(int tr, int rr, int tu, int ru, int d, int nt);
    int rre;
    int total;
    rst_n = 1'b0; ref_in = 1'b0; unk_in = 1'b0;
    ref_ratio = DIV_W'(rr); unk_ratio = DIV_W'(ru);
    repeat (3) @(negedge clk);
    chk("R1 pwm", int'(pwm_out), 0);
    chk("R1 word", int'(phase_word), 0);
    chk("R1 valid", int'(phase_valid), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    n_valid = 0; pwm_cnt = 0; mon_on = 1;
    rre = (rr == 0) ? 1 : rr;
    total = nt * rre * tr + 4;
    for (int c = 0; c < total; c++) begin
      @(posedge clk); #2;
      ref_in = (c % tr == 0) && (c / tr < nt * rre);
      unk_in = (tu != 0) && (c >= d) && ((c - d) % tu == 0);
    end
    ref_in = 1'b0; unk_in = 1'b0;
    repeat (3) @(posedge clk);
    #2; mon_on = 0;
    chk("R6 valid count", n_valid, nt - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // table walk: steady phase for several ratio pairs
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 8; k++) begin
        exp_w[k] = VEC[v][5];
        exp_p[k] = VEC[v][5];
      end
      tag_w = (v == 2) ? "R4 coincident word" : (v == 4) ? "R2 zero ratio word" : "R5 word";
      tag_p = (v == 2) ? "R4 coincident pwm" : "R3 pwm high time";
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 5);
    end

    // R7: unknown period 19 against reference period 20 -> 3,2,1,0 then fold to 18
    exp_w[0] = 3; exp_w[1] = 2; exp_w[2] = 1; exp_w[3] = 0; exp_w[4] = 18;
    for (int k = 0; k < 8; k++) exp_p[k] = exp_w[k];
    tag_w = "R7 wrap word"; tag_p = "R7 wrap pwm";
    run(4, 5, 19, 1, 0, 6);

    // R8: no unknown edges, 40-cycle period saturates a 5-bit word
    for (int k = 0; k < 8; k++) begin exp_w[k] = 31; exp_p[k] = 40; end
    tag_w = "R8 saturated word"; tag_p = "R8 pwm full period";
    run(4, 10, 0, 1, 0, 5);

    // R1: asynchronous reset in the middle of activity
    ref_ratio = 8'd1; unk_ratio = 8'd1;
    @(posedge clk); #2; ref_in = 1'b1;
    @(posedge clk); #2; ref_in = 1'b0;
    @(negedge clk);
    chk("R3 pwm rises after ref event", int'(pwm_out), 1);
    #3; rst_n = 1'b0;
    #1;
    chk("R1 async pwm clear", int'(pwm_out), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule